// File: doc/BRIEF.md
# Indexed-Window SPI Flash Bridge

This block lets a host reach a serial flash through a four-byte I/O window. Two of the window bytes form a 16-bit internal address (high byte and low byte). A third byte is the data port that reads or writes the internal register at that address. Three internal registers drive an SPI master. A configuration register holds chip-select under software control and shows a busy flag. A command register starts a byte shift when it is written. A data register keeps the byte captured from the flash.

A typical flash command runs as follows. Software drives chip-select low with a configuration write and waits a few cycles. It then writes each command and address byte to the command register, polling busy between bytes. To clock in each read byte it writes 0x00 and reads the data register. Finally it releases chip-select. The serial side uses SPI mode 0: SCK idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge. The SCK period is 2·DIV clock cycles.

Top module: `spi_window_bridge`

## Requirements
- R1: Window port 1 holds the high address byte and port 2 holds the low address byte. Both read back their last written value. Port 0 reads 0x00 and writes to it have no effect.
- R2: Port 3 accesses the internal register at {high,low}. 0xFEAB is the data register, 0xFEAC the command register and 0xFEAD the configuration register. Any other internal address reads 0x00, and writes to it change nothing. The data register is read-only.
- R3: Configuration bit 4 drives spi_cs_n low while it is set. A write changes bit 4 only when bit 3 of the same written byte is 1. The other writable bits (7:2 except 4, and bit 0) are stored as written.
- R4: Configuration bit 1 is read-only. It reads 1 while a shift is in progress and bit 0 is set. It reads 0 when the shifter is idle or when bit 0 is clear.
- R5: A write to the command register while idle shifts the byte out on spi_mosi, MSB first, in SPI mode 0. SCK idles low, MOSI is stable while SCK is high, and each SCK half-period lasts DIV clock cycles.
- R6: During the shift, 8 bits are sampled from spi_miso on the SCK rising edges, MSB first. The result is loaded into the data register when the shift ends. The data register holds this byte until the next shift completes, so writing 0x00 acts as a pure read clock.
- R7: A command-register write made while a shift is in progress is ignored. The running byte completes unchanged and no second byte is sent.
- R8: After reset spi_cs_n is 1, spi_sck is 0, the shifter is idle, and the configuration, data and address registers are 0x00.
- R9: The busy state lasts exactly 16·DIV clock cycles, counted from the clock edge that accepts the command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Window port select (0..3) |
| host_wr | input | 1 | Write strobe for the selected port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected port (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | 1 | Flash chip-select, active low |

## Verification
The in-module assertions check several rules on every cycle. SCK stays low when no shift is running. MOSI holds steady while SCK is high. An accepted command write starts a shift with its MSB on MOSI. Chip-select changes only after a configuration write with the enable bit set. The masked busy bit and unmapped addresses read zero. The data register changes only when a shift ends. The bench scenarios show what a property cannot see: the full MOSI byte order (through a scoreboard of expected bytes), the MISO byte captured into the data register, that a command written while busy is dropped, and the exact busy length.

// File: rtl/spi_window_bridge.sv
module spi_window_bridge #(
  parameter int          DIV      = 2,
  parameter logic [15:0] REG_DATA = 16'hFEAB,
  parameter logic [15:0] REG_CMD  = 16'hFEAC,
  parameter logic [15:0] REG_CFG  = 16'hFEAD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(DIV - 1);

  logic [7:0]    hi_q, lo_q, cfg_q, data_q, cmd_q, tx_q, rx_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic          busy_q, sck_q;

  wire [15:0] iaddr   = {hi_q, lo_q};
  wire        wr_data = host_wr && (host_addr == 2'd3);
  wire        wr_cfg  = wr_data && (iaddr == REG_CFG);
  wire        wr_cmd  = wr_data && (iaddr == REG_CMD);
  wire        launch  = wr_cmd && !busy_q;
  wire        tick    = busy_q && (cnt_q == CNT_TOP);
  wire        busy_rd = busy_q && cfg_q[0];

  assign spi_sck  = sck_q;
  assign spi_mosi = busy_q & tx_q[7];
  assign spi_cs_n = ~cfg_q[4];

  // host window registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 8'h00;
      lo_q  <= 8'h00;
      cfg_q <= 8'h00;
      cmd_q <= 8'h00;
    end else begin
      if (host_wr && host_addr == 2'd1) hi_q <= host_wdata;
      if (host_wr && host_addr == 2'd2) lo_q <= host_wdata;
      if (wr_cfg) begin
        cfg_q[7:5] <= host_wdata[7:5];
        cfg_q[3:2] <= host_wdata[3:2];
        cfg_q[0]   <= host_wdata[0];
        cfg_q[1]   <= 1'b0;
        if (host_wdata[3]) cfg_q[4] <= host_wdata[4];
      end
      if (launch) cmd_q <= host_wdata;
    end
  end

  // mode-0 byte shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= 3'd0;
      tx_q   <= 8'h00;
      rx_q   <= 8'h00;
      data_q <= 8'h00;
    end else if (launch) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= 3'd0;
      tx_q   <= host_wdata;
    end else if (busy_q) begin
      if (!tick) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], spi_miso};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            data_q <= rx_q;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  // read mux
  always_comb begin
    host_rdata = 8'h00;
    case (host_addr)
      2'd1: host_rdata = hi_q;
      2'd2: host_rdata = lo_q;
      2'd3: begin
        if (iaddr == REG_DATA)     host_rdata = data_q;
        else if (iaddr == REG_CMD) host_rdata = cmd_q;
        else if (iaddr == REG_CFG) host_rdata = {cfg_q[7:2], busy_rd, cfg_q[0]};
      end
      default: host_rdata = 8'h00;
    endcase
  end

  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !spi_sck);
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  p_launch_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !busy_q) |=> (busy_q && spi_mosi == $past(host_wdata[7])));
  p_cs_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_cfg && host_wdata[3]) |=> $stable(spi_cs_n));
  p_busy_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 2'd3 && iaddr == REG_CFG && !cfg_q[0]) |-> !host_rdata[1]);
  p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 2'd3 && iaddr != REG_DATA && iaddr != REG_CMD && iaddr != REG_CFG)
      |-> host_rdata == 8'h00);
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_q) |-> $stable(data_q));

endmodule

// File: tb/spi_window_bridge_test.sv
module spi_window_bridge_test;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       spi_sck, spi_mosi, spi_cs_n;
  logic [7:0] pat = 8'h00;
  int         rise_cnt = 0;
  logic       spi_miso;

  int checks = 0, failures = 0, bytes_seen = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  spi_window_bridge #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  assign spi_miso = pat[7 - (rise_cnt % 8)];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: collects MOSI bytes and compares with the scoreboard
  always @(posedge spi_sck) begin : mon
    static logic [7:0] sh = 8'h00;
    sh = {sh[6:0], spi_mosi};
    rise_cnt = rise_cnt + 1;
    if (rise_cnt % 8 == 0) begin
      bytes_seen++;
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R7 actual=%0h expected=none", sh);
      end else begin
        check("R5 mosi byte", {24'd0, sh}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    host_addr = p; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic sel(input logic [15:0] a);
    wr(2'd1, a[15:8]);
    wr(2'd2, a[7:0]);
    host_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] p, output logic [7:0] d);
    @(negedge clk);
    host_addr = p; #1;
    d = host_rdata;
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
    sel(a);
    rd(2'd3, d);
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] miso_b);
    pat = miso_b;
    exp_q.push_back(b);
    sel(16'hFEAC);
    wr(2'd3, b);
  endtask

  task automatic wait_idle;
    repeat (16 * DIV + 4) @(posedge clk);
  endtask

  initial begin : watchdog
    #1600000;
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : drive
    logic [7:0] d;
    int cyc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8 reset state
    check("R8 cs_n", {31'd0, spi_cs_n}, 1);
    check("R8 sck", {31'd0, spi_sck}, 0);
    rd(2'd1, d); check("R8 high addr", {24'd0, d}, 0);
    rd_reg(16'hFEAD, d); check("R8 cfg", {24'd0, d}, 0);
    rd_reg(16'hFEAB, d); check("R8 data", {24'd0, d}, 0);

    // R1 window readback
    wr(2'd1, 8'h5A); wr(2'd2, 8'hC3);
    rd(2'd1, d); check("R1 high", {24'd0, d}, 32'h5A);
    rd(2'd2, d); check("R1 low", {24'd0, d}, 32'hC3);
    wr(2'd0, 8'h77);
    rd(2'd0, d); check("R1 port0", {24'd0, d}, 0);

    // R2 unmapped
    sel(16'h1234); wr(2'd3, 8'h55);
    rd(2'd3, d); check("R2 unmapped", {24'd0, d}, 0);
    rd_reg(16'hFEAD, d); check("R2 cfg untouched", {24'd0, d}, 0);

    // R3 chip-select gating
    sel(16'hFEAD); wr(2'd3, 8'h11);
    check("R3 cs no enable", {31'd0, spi_cs_n}, 1);
    rd(2'd3, d); check("R3 cfg bits", {24'd0, d}, 32'h01);
    wr(2'd3, 8'h19);
    check("R3 cs forced", {31'd0, spi_cs_n}, 0);
    rd(2'd3, d); check("R3 cfg read", {24'd0, d}, 32'h19);
    repeat (4) @(posedge clk);

    // R5/R6/R4/R9 first byte with busy checking enabled
    send(8'hA5, 8'h3C);
    wr(2'd2, 8'hAD);
    cyc = 1;
    rd(2'd3, d); check("R4 busy set", {31'd0, d[1]}, 1);
    while (d[1] && cyc < 200) begin
      @(posedge clk); #1; cyc++;
      d = host_rdata;
    end
    check("R9 busy length", cyc, 16 * DIV);
    rd_reg(16'hFEAB, d); check("R6 captured", {24'd0, d}, 32'h3C);

    // R7 write while busy ignored
    send(8'h81, 8'hE7);
    wr(2'd3, 8'hFF);
    wait_idle;
    check("R7 byte count", bytes_seen, 2);
    rd_reg(16'hFEAC, d); check("R7 cmd kept", {24'd0, d}, 32'h81);
    rd_reg(16'hFEAB, d); check("R6 second capture", {24'd0, d}, 32'hE7);

    // R4 masked busy
    sel(16'hFEAD); wr(2'd3, 8'h00);
    check("R3 cs kept low", {31'd0, spi_cs_n}, 0);
    send(8'h3B, 8'h96);
    sel(16'hFEAD);
    rd(2'd3, d); check("R4 masked", {31'd0, d[1]}, 0);
    wait_idle;

    // R6 read clock and data hold
    send(8'h00, 8'h5E);
    wait_idle;
    sel(16'hFEAB); wr(2'd3, 8'h11);
    rd(2'd3, d); check("R6 read clock", {24'd0, d}, 32'h5E);
    repeat (10) @(posedge clk);
    rd(2'd3, d); check("R6 hold", {24'd0, d}, 32'h5E);
    check("R5 sck idle", {31'd0, spi_sck}, 0);

    // R3 release
    sel(16'hFEAD); wr(2'd3, 8'h08);
    check("R3 cs released", {31'd0, spi_cs_n}, 1);
    check("R5 all bytes", bytes_seen, 4);
    check("R5 queue empty", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule